// File: doc/BRIEF.md
# Serial Port Interrupt Status and Control Registers

This block is the register file for a serial port. It sits on a 32-bit strobe bus with word addressing. It holds the control register and the baud-rate divider register. It reports the receive and transmit FIFO fill levels, and it passes data-port accesses through to the datapath as single-cycle strobes. The serial datapaths are outside the block. They appear only as event pulses (transmit request, framing error, break, overrun), as live levels (RX and TX FIFO fill, receive timeout), and as the received data word.

Event pulses are caught in sticky status bits that software clears by writing ones. Two status bits have no storage and follow the datapath directly: the RX threshold comparison and the receive timeout. A single interrupt output combines the status with three class enables, one each for errors, receive and transmit.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the control register reads 0, the rate register reads 0xFF, the status register reads 0 and irq_o is low.
- R2: Word 1 (level) reads the TX fill level in bits 15:8 and the RX fill level in bits 7:0, with the upper bits zero.
- R3: Status is read at word 2. Four event pulses set sticky bits that stay set until cleared: transmit request sets bit 0, framing error sets bit 3, break sets bit 4 and overrun sets bit 5.
- R4: A write to word 2 clears each sticky bit (0, 3, 4, 5) whose position holds a one. Sticky bits whose position holds a zero are unchanged.
- R5: When an event pulse arrives in the same cycle as a clear write to its bit, the bit remains set.
- R6: Status bit 1 is live and is high while the RX fill level is at or above the threshold chosen by control bits 4:2. The codes are 0→1, 1→4, 2→8, 3→16, 4→32, and 5 or above→48. Bit 1 drops as soon as the level falls below the threshold.
- R7: Status bit 2 follows the receive-timeout input directly. Writing ones to bits 1 or 2 of word 2 has no effect.
- R8: irq_o is high when any of the following holds: control bit 7 is set and any of status bits 3–5 is set; control bit 6 is set and status bit 1 or 2 is set; control bit 5 is set and status bit 0 is set.
- R9: Status bit 6 reads as status bit 0 AND control bit 5.
- R10: Control (word 3) stores bits 21:0 and reads zero above them. break_o equals control bit 8. Rate (word 4) stores bits 7:0.
- R11: A read of word 0 returns the RX data word, zero-extended, and pulses fifo_rd_o for that cycle. A write to word 0 pulses fifo_wr_o with wdata bits 7:0 on fifo_wdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word address |
| wen_i | input | 1 | Write strobe |
| ren_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| rx_data_i | input | 11 | RX data word from the datapath |
| rx_level_i | input | 8 | RX FIFO fill level |
| tx_level_i | input | 8 | TX FIFO fill level |
| rx_tmo_i | input | 1 | Live receive-timeout condition |
| tx_evt_i | input | 1 | Transmit request pulse |
| fe_evt_i | input | 1 | Framing error pulse |
| brk_evt_i | input | 1 | Break received pulse |
| ovr_evt_i | input | 1 | Overrun pulse |
| fifo_rd_o | output | 1 | Data-port read strobe |
| fifo_wr_o | output | 1 | Data-port write strobe |
| fifo_wdata_o | output | 8 | Data-port write byte |
| ctrl_o | output | 32 | Control register contents |
| rate_o | output | 8 | Rate register contents |
| break_o | output | 1 | Force break on the transmit line |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that event inputs are single-cycle pulses that are already synchronous to clk_i. They also assume that a clear write and the pulse it races with are sampled at the same edge. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. This keeps the set-versus-clear race at a single edge, which is the case that R5 defines. The bench changes level inputs only between accesses, so each read sees a stable comparison.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_LVL  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_RATE = 3'd4
  } reg_sel_e;

  localparam int unsigned ST_TX   = 0;
  localparam int unsigned ST_RXTH = 1;
  localparam int unsigned ST_TMO  = 2;
  localparam int unsigned ST_FE   = 3;
  localparam int unsigned ST_BRK  = 4;
  localparam int unsigned ST_OVR  = 5;
  localparam int unsigned ST_TXON = 6;

  localparam int unsigned CT_TXEN  = 5;
  localparam int unsigned CT_RXEN  = 6;
  localparam int unsigned CT_ERREN = 7;
  localparam int unsigned CT_BRK   = 8;
  localparam int unsigned CT_RXSEL = 2;

  localparam logic [31:0] CTRL_MASK = 32'h003F_FFFF;

  localparam int unsigned N_STICKY = 4;
  // sticky slot -> status bit position
  function automatic int unsigned sticky_pos(int unsigned k);
    case (k)
      0:       return ST_TX;
      1:       return ST_FE;
      2:       return ST_BRK;
      default: return ST_OVR;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_w1c.sv
module uart_irq_w1c #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_q <= 1'b0;
      else if (set_i[g]) q_q <= 1'b1;   // set wins over clear
      else if (clr_i[g]) q_q <= 1'b0;
    end
    assign q_o[g] = q_q;
  end
endmodule

// File: rtl/uart_irq_rxthr.sv
module uart_irq_rxthr #(
  parameter int unsigned LVL_W = 8
) (
  input  logic [2:0]       sel_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             hit_o
);
  logic [LVL_W-1:0] thr;
  always_comb begin
    case (sel_i)
      3'd0:    thr = LVL_W'(1);
      3'd1:    thr = LVL_W'(4);
      3'd2:    thr = LVL_W'(8);
      3'd3:    thr = LVL_W'(16);
      3'd4:    thr = LVL_W'(32);
      default: thr = LVL_W'(48);
    endcase
  end
  assign hit_o = (level_i >= thr);
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned DATA_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wen_i,
  input  logic              ren_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic              rx_tmo_i,
  input  logic              tx_evt_i,
  input  logic              fe_evt_i,
  input  logic              brk_evt_i,
  input  logic              ovr_evt_i,
  output logic              fifo_rd_o,
  output logic              fifo_wr_o,
  output logic [7:0]        fifo_wdata_o,
  output logic [31:0]       ctrl_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              break_o,
  output logic              irq_o
);
  localparam logic [RATE_W-1:0] RATE_RST = '1;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  logic [31:0]       ctrl_q;
  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rate_q <= RATE_RST;
    end else if (wen_i) begin
      if (sel == SEL_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (sel == SEL_RATE) rate_q <= wdata_i[RATE_W-1:0];
    end
  end

  // sticky event bits
  logic [N_STICKY-1:0] evt_set, evt_clr, evt_q;
  logic                clr_wr;
  assign clr_wr  = wen_i && (sel == SEL_STAT);
  assign evt_set = {ovr_evt_i, brk_evt_i, fe_evt_i, tx_evt_i};
  for (genvar k = 0; k < N_STICKY; k++) begin : g_clr
    assign evt_clr[k] = clr_wr && wdata_i[sticky_pos(k)];
  end

  uart_irq_w1c #(.W(N_STICKY)) u_w1c (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .q_o    (evt_q)
  );

  logic rx_hit;
  uart_irq_rxthr #(.LVL_W(LVL_W)) u_rxthr (
    .sel_i   (ctrl_q[CT_RXSEL+:3]),
    .level_i (rx_level_i),
    .hit_o   (rx_hit)
  );

  logic [31:0] stat;
  always_comb begin
    stat          = '0;
    stat[ST_TX]   = evt_q[0];
    stat[ST_FE]   = evt_q[1];
    stat[ST_BRK]  = evt_q[2];
    stat[ST_OVR]  = evt_q[3];
    stat[ST_RXTH] = rx_hit;
    stat[ST_TMO]  = rx_tmo_i;
    stat[ST_TXON] = evt_q[0] & ctrl_q[CT_TXEN];
  end

  logic err_irq, rx_irq, tx_irq;
  assign err_irq = ctrl_q[CT_ERREN] & (stat[ST_FE] | stat[ST_BRK] | stat[ST_OVR]);
  assign rx_irq  = ctrl_q[CT_RXEN]  & (stat[ST_RXTH] | stat[ST_TMO]);
  assign tx_irq  = stat[ST_TXON];
  assign irq_o   = err_irq | rx_irq | tx_irq;

  always_comb begin
    case (sel)
      SEL_DATA: rdata_o = 32'(rx_data_i);
      SEL_LVL:  rdata_o = {16'h0, 8'(tx_level_i), 8'(rx_level_i)};
      SEL_STAT: rdata_o = stat;
      SEL_CTRL: rdata_o = ctrl_q;
      SEL_RATE: rdata_o = 32'(rate_q);
      default:  rdata_o = '0;
    endcase
  end

  assign fifo_rd_o    = ren_i && (sel == SEL_DATA);
  assign fifo_wr_o    = wen_i && (sel == SEL_DATA);
  assign fifo_wdata_o = wdata_i[7:0];
  assign ctrl_o       = ctrl_q;
  assign rate_o       = rate_q;
  assign break_o      = ctrl_q[CT_BRK];
endmodule

// File: rtl/uart_irq_regs_chk.sv
module uart_irq_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic        wen_i,
  input logic        ren_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        fe_evt_i,
  input logic        brk_evt_i,
  input logic        fifo_rd_o,
  input logic [31:0] ctrl_o,
  input logic        irq_o
);
  AST_FE_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_evt_i |=> (addr_i != 3'd2) || rdata_o[3]) else $error("fe set lost"); // R5

  AST_BRK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd2 && rdata_o[4] && !(wen_i && wdata_i[4])) |=>
      (addr_i != 3'd2) || rdata_o[4]) else $error("brk dropped"); // R3

  AST_FE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && addr_i == 3'd2 && wdata_i[3] && !fe_evt_i) |=>
      (addr_i != 3'd2) || !rdata_o[3]) else $error("fe not cleared"); // R4

  AST_NO_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7:5] == 3'b000) |-> !irq_o) else $error("irq while disabled"); // R8

  AST_RD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> (ren_i && addr_i == 3'd0)) else $error("stray rd"); // R11

  AST_CTRL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[31:22] == 10'h0) else $error("rsvd ctrl"); // R10

  logic unused_brk;
  assign unused_brk = brk_evt_i;
endmodule

bind uart_irq_regs uart_irq_regs_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wen_i     (wen_i),
  .ren_i     (ren_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .fe_evt_i  (fe_evt_i),
  .brk_evt_i (brk_evt_i),
  .fifo_rd_o (fifo_rd_o),
  .ctrl_o    (ctrl_o),
  .irq_o     (irq_o)
);

// File: tb/uart_irq_regs_tb_top.sv
`timescale 1ns/1ps
module uart_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wen = 1'b0, ren = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] rx_data = 11'h1A5;
  logic [7:0]  rx_level = '0, tx_level = 8'h12;
  logic        rx_tmo = 1'b0;
  logic        tx_evt = 1'b0, fe_evt = 1'b0, brk_evt = 1'b0, ovr_evt = 1'b0;
  logic        fifo_rd, fifo_wr, brk_o, irq;
  logic [7:0]  fifo_wdata, rate;
  logic [31:0] ctrl;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wen_i(wen), .ren_i(ren),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data),
    .rx_level_i(rx_level), .tx_level_i(tx_level), .rx_tmo_i(rx_tmo),
    .tx_evt_i(tx_evt), .fe_evt_i(fe_evt), .brk_evt_i(brk_evt),
    .ovr_evt_i(ovr_evt), .fifo_rd_o(fifo_rd), .fifo_wr_o(fifo_wr),
    .fifo_wdata_o(fifo_wdata), .ctrl_o(ctrl), .rate_o(rate),
    .break_o(brk_o), .irq_o(irq)
  );

  typedef struct packed {
    logic        is_wr;
    logic [2:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd4, 32'h0000_00FF, 4'd1},   // R1 rate reset
    '{1'b0, 3'd3, 32'h0000_0000, 4'd1},   // R1 ctrl reset
    '{1'b0, 3'd2, 32'h0000_0000, 4'd1},   // R1 status reset
    '{1'b1, 3'd4, 32'hABCD_1234, 4'd10},
    '{1'b0, 3'd4, 32'h0000_0034, 4'd10},  // R10 rate width
    '{1'b1, 3'd3, 32'hFFFF_FFFF, 4'd10},
    '{1'b0, 3'd3, 32'h003F_FFFF, 4'd10},  // R10 ctrl mask
    '{1'b1, 3'd3, 32'h0000_0000, 4'd10},
    '{1'b0, 3'd1, 32'h0000_1200, 4'd2},   // R2 levels
    '{1'b0, 3'd0, 32'h0000_01A5, 4'd11}   // R11 data read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  function automatic logic [31:0] rd(input logic [2:0] a);
    addr = a;
    return rdata;
  endfunction

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: tx_evt = 1'b1;
      1: fe_evt = 1'b1;
      2: brk_evt = 1'b1;
      default: ovr_evt = 1'b1;
    endcase
    @(negedge clk);
    tx_evt = 1'b0; fe_evt = 1'b0; brk_evt = 1'b0; ovr_evt = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_wr) wr(VECS[i].a, VECS[i].d);
      else begin
        addr = VECS[i].a; ren = 1'b1; #1;
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), rdata, VECS[i].d);
        @(negedge clk); ren = 1'b0;
      end
    end

    // R3 sticky latch
    pulse(1);
    rdchk("R3 fe set", 3'd2, 32'h08);
    repeat (3) @(negedge clk);
    rdchk("R3 fe held", 3'd2, 32'h08);
    pulse(2); pulse(3);
    rdchk("R3 brk ovr set", 3'd2, 32'h38);

    // R4 selective clear
    wr(3'd2, 32'h0000_0021);
    rdchk("R4 ovr cleared only", 3'd2, 32'h18);
    wr(3'd2, 32'h0000_0018);
    rdchk("R4 all cleared", 3'd2, 32'h00);

    // R5 set beats clear
    pulse(2);
    fe_evt = 1'b1; brk_evt = 1'b1;
    wr(3'd2, 32'h0000_0018);
    fe_evt = 1'b0; brk_evt = 1'b0;
    rdchk("R5 set wins", 3'd2, 32'h18);
    wr(3'd2, 32'h0000_0018);

    // R6 rx threshold
    wr(3'd3, 32'h0000_0004);
    rx_level = 8'd3; rdchk("R6 below 4", 3'd2, 32'h00);
    rx_level = 8'd4; rdchk("R6 at 4", 3'd2, 32'h02);
    wr(3'd3, 32'h0000_0014);
    rx_level = 8'd47; rdchk("R6 below 48", 3'd2, 32'h00);
    rx_level = 8'd48; rdchk("R6 at 48", 3'd2, 32'h02);
    wr(3'd3, 32'h0000_001C);
    rdchk("R6 code7 48", 3'd2, 32'h02);
    wr(3'd3, 32'h0000_0000);
    rx_level = 8'd0; rdchk("R6 drained", 3'd2, 32'h00);
    rx_level = 8'd1; rdchk("R6 code0 one", 3'd2, 32'h02);
    rx_level = 8'd0;

    // R7 timeout live, not clearable
    rx_tmo = 1'b1;
    rdchk("R7 tmo", 3'd2, 32'h04);
    wr(3'd2, 32'h0000_0006);
    rdchk("R7 write ignored", 3'd2, 32'h04);
    rx_tmo = 1'b0;
    rdchk("R7 tmo gone", 3'd2, 32'h00);

    // R8 grouped enables
    pulse(1);
    #1 chk("R8 no enable", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0000_0040);
    #1 chk("R8 rx en, fe only", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0000_0080);
    #1 chk("R8 err en", {31'h0, irq}, 32'h1);
    wr(3'd2, 32'h0000_0008);
    #1 chk("R8 err cleared", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0000_0040);
    rx_tmo = 1'b1; #1 chk("R8 rx tmo", {31'h0, irq}, 32'h1);
    rx_tmo = 1'b0;
    pulse(0);
    #1 chk("R8 tx not enabled", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0000_0020);
    #1 chk("R8 tx en", {31'h0, irq}, 32'h1);

    // R9 tx-interrupt-set flag
    rdchk("R9 flag on", 3'd2, 32'h41);
    wr(3'd3, 32'h0000_0000);
    rdchk("R9 flag off", 3'd2, 32'h01);
    wr(3'd2, 32'h0000_0001);
    rdchk("R4 tx cleared", 3'd2, 32'h00);

    // R10 break
    wr(3'd3, 32'h0000_0100);
    #1 chk("R10 break", {31'h0, brk_o}, 32'h1);
    wr(3'd3, 32'h0000_0000);
    #1 chk("R10 break off", {31'h0, brk_o}, 32'h0);

    // R11 data port strobes
    addr = 3'd0; wdata = 32'h0000_0155; wen = 1'b1; #1;
    chk("R11 wr strobe", {23'h0, fifo_wr, fifo_wdata}, {23'h0, 1'b1, 8'h55});
    chk("R11 no rd on wr", {31'h0, fifo_rd}, 32'h0);
    @(negedge clk); wen = 1'b0; #1;
    chk("R11 wr idle", {31'h0, fifo_wr}, 32'h0);
    ren = 1'b1; #1;
    chk("R11 rd strobe", {31'h0, fifo_rd}, 32'h1);
    @(negedge clk); ren = 1'b0;
    addr = 3'd1; ren = 1'b1; #1;
    chk("R11 rd other addr", {31'h0, fifo_rd}, 32'h0);
    @(negedge clk); ren = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule